// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block keeps the interrupt bookkeeping for a single processor. It holds three 256-bit vectors indexed by interrupt vector number: pending requests, vectors currently in service, and the trigger mode recorded for each vector. It also holds a task priority byte and a spurious/enable control register. Request sources post a vector with a level-or-edge flag. The processor acknowledges to fetch the vector it should service, and it signals end-of-interrupt when the handler finishes.

A higher vector number means a higher priority. Each vector belongs to a 4-bit priority class formed by its top nibble. The processor priority is the larger of the task priority and the class of the highest in-service vector. A request is signalled only when its class is above that priority. An acknowledge made while the best request is blocked returns the spurious vector and changes no state. When a level-triggered vector is retired, a broadcast pulse carrying that vector is emitted so that upstream level sources can re-sample.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The vector returned on a deliverable acknowledge is the highest-numbered set request bit, across all eight 32-bit words of the 256-bit request vector.
- R2: `ppr` equals the full task priority byte when task priority bits 7:4 are greater than or equal to bits 7:4 of the highest in-service vector. Otherwise it equals that in-service class in bits 7:4 with bits 3:0 zero. An empty in-service set counts as vector 0.
- R3: `irq_pending` is 1 only when spurious register bit 8 (enable) is 1 and some request bit is set, and the request is not blocked. A request is blocked when `ppr` is non-zero and bits 7:4 of the highest request are less than or equal to `ppr` bits 7:4.
- R4: On an acknowledge, `ack_vld` pulses on the next cycle whenever the block is enabled and a request exists. A blocked request returns spurious register bits 7:0 and leaves all state unchanged. A deliverable request returns its vector, clears its request bit and sets its in-service bit. With no request or while disabled, `ack_vld` stays 0.
- R5: Posting a vector sets its request bit. It sets the vector's trigger-mode bit when `set_lvl` is 1 (level) and clears it when `set_lvl` is 0 (edge); the most recent post decides.
- R6: End-of-interrupt clears the highest set in-service bit. If that vector's trigger-mode bit is 1 and the suppression flag is clear, `eoi_bcast` pulses on the next cycle with `eoi_vec` holding the vector. An end-of-interrupt with an empty in-service set does nothing.
- R7: A spurious register write stores `spur_wdata` bits 8:0 only. With the default parameters, bit 12 (suppression) is discarded, so level-triggered retirements still broadcast after it is written as 1.
- R8: A nibble task-priority write stores `tpr_nib` in task priority bits 7:4 with bits 3:0 zero. A full-byte write in the same cycle takes precedence.
- R9: `irq_pending` and `ppr` reflect a state change one cycle after the edge that made it. An acknowledge and an end-of-interrupt in the same cycle are processed acknowledge first, so the end-of-interrupt may retire the vector just acknowledged.
- R10: Reset clears all three bit vectors and the task priority, and loads the spurious register with 0x0FF (disabled). After reset, `irq_pending`, `ppr`, `ack_vld` and `eoi_bcast` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_vld | input | 1 | Post a vector request this cycle |
| set_vec | input | 8 | Vector being posted |
| set_lvl | input | 1 | Trigger of posted vector: 1 level, 0 edge |
| ack | input | 1 | Acknowledge strobe from the processor |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Full-byte task priority write |
| tpr_wdata | input | 8 | Task priority byte |
| tpr_nib_we | input | 1 | Nibble task priority write |
| tpr_nib | input | 4 | Task priority class for the nibble write |
| spur_we | input | 1 | Spurious/enable register write |
| spur_wdata | input | 16 | Spurious register write data (bit 8 enable, bit 12 suppression, bits 7:0 spurious vector) |
| irq_pending | output | 1 | A deliverable request exists |
| ack_vld | output | 1 | Acknowledge response valid |
| ack_vec | output | 8 | Acknowledged or spurious vector |
| ppr | output | 8 | Processor priority |
| eoi_bcast | output | 1 | Retirement broadcast pulse |
| eoi_vec | output | 8 | Vector carried by the broadcast |

## Verification
A corrupted request or in-service bit becomes visible at the next acknowledge, as the wrong vector or a spurious return. It also shows in `irq_pending` and `ppr` one cycle after the corrupting edge, because both are re-derived every cycle from the stored vectors. A lost or stale trigger-mode bit shows only when that vector retires, as a missing or extra `eoi_bcast`. Trigger-mode faults can therefore remain hidden through a full acknowledge/retire round trip. For that reason the scenarios drive each posted vector through acknowledge and end-of-interrupt and compare the broadcast.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int VEC_W     = 8;
    localparam int CLS_W     = 4;
    localparam int SPUR_W    = 9;
    localparam int SPUR_IN_W = 16;
    localparam int SUPP_BIT  = 12;
    localparam int EN_BIT    = 8;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CLS_W-1:0] cls_t;

    typedef struct packed {
        logic vld;
        vec_t vec;
    } vec_evt_t;

    typedef struct packed {
        vec_t ppr;
        logic has_req;
        logic blocked;
    } arb_t;

    function automatic cls_t class_of(input vec_t v);
        return v[VEC_W-1 -: CLS_W];
    endfunction

endpackage

// File: rtl/prio_irq_scan.sv
module prio_irq_scan #(
    parameter int N = 256,
    parameter int W = 32
) (
    input  logic [N-1:0]         bits,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int NW = N / W;
    localparam int LW = $clog2(W);
    localparam int IW = $clog2(N);

    function automatic logic [LW-1:0] top_of(input logic [W-1:0] w);
        logic [LW-1:0] r;
        r = '0;
        for (int b = 0; b < W; b++) begin
            if (w[b]) r = LW'(b);
        end
        return r;
    endfunction

    logic [NW-1:0] wfound;
    logic [LW-1:0] widx [NW];

    for (genvar g = 0; g < NW; g++) begin : g_word
        assign wfound[g] = |bits[g*W +: W];
        assign widx[g]   = top_of(bits[g*W +: W]);
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < NW; w++) begin
            if (wfound[w]) begin
                found = 1'b1;
                idx   = IW'(w * W + int'(widx[w]));
            end
        end
    end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import prio_irq_pkg::*;
(
    input  logic req_found,
    input  vec_t req_vec,
    input  logic svc_found,
    input  vec_t svc_vec,
    input  vec_t tpr,
    input  logic enable,
    output arb_t arb
);
    cls_t svc_cls;
    vec_t ppr_v;

    always_comb begin
        svc_cls = svc_found ? class_of(svc_vec) : '0;
        if (class_of(tpr) >= svc_cls) ppr_v = tpr;
        else                          ppr_v = {svc_cls, {(VEC_W-CLS_W){1'b0}}};
        arb.ppr     = ppr_v;
        arb.has_req = enable && req_found;
        arb.blocked = (ppr_v != '0) && (class_of(req_vec) <= class_of(ppr_v));
    end
endmodule

// File: rtl/prio_irq_vecs.sv
module prio_irq_vecs #(
    parameter int N = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_vld,
    input  logic [$clog2(N)-1:0] set_vec,
    input  logic                 set_lvl,
    input  logic                 take_vld,
    input  logic [$clog2(N)-1:0] take_vec,
    input  logic                 retire_vld,
    input  logic [$clog2(N)-1:0] retire_vec,
    output logic [N-1:0]         irr,
    output logic [N-1:0]         isr,
    output logic [N-1:0]         tmr,
    output logic [N-1:0]         isr_mid
);
    logic [N-1:0] take_1h;
    logic [N-1:0] irr_n, isr_n, tmr_n;

    assign take_1h = take_vld ? (N'(1) << take_vec) : '0;
    assign isr_mid = isr | take_1h;

    always_comb begin
        irr_n = irr & ~take_1h;
        isr_n = isr_mid;
        tmr_n = tmr;
        if (retire_vld) isr_n[retire_vec] = 1'b0;
        if (set_vld) begin
            irr_n[set_vec] = 1'b1;
            tmr_n[set_vec] = set_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            irr <= irr_n;
            isr <= isr_n;
            tmr <= tmr_n;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int N_VEC       = 256,
    parameter int WORD_W      = 32,
    parameter bit SUPPRESS_EN = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        set_vld,
    input  logic [7:0]  set_vec,
    input  logic        set_lvl,
    input  logic        ack,
    input  logic        eoi,
    input  logic        tpr_we,
    input  logic [7:0]  tpr_wdata,
    input  logic        tpr_nib_we,
    input  logic [3:0]  tpr_nib,
    input  logic        spur_we,
    input  logic [15:0] spur_wdata,
    output logic        irq_pending,
    output logic        ack_vld,
    output logic [7:0]  ack_vec,
    output logic [7:0]  ppr,
    output logic        eoi_bcast,
    output logic [7:0]  eoi_vec
);
    localparam int IW = $clog2(N_VEC);

    logic [N_VEC-1:0] irr, isr, tmr, isr_mid;
    logic             req_found, svc_found, mid_found;
    logic [IW-1:0]    req_idx, svc_idx, mid_idx;
    arb_t             arb;

    vec_t             tpr_q;
    logic [SPUR_W-1:0] spur_q;
    logic             supp_q;
    logic             pend_q;
    vec_t             ppr_q;
    vec_evt_t         ack_q, bc_q;

    logic             take, retire, bc_fire;

    prio_irq_scan #(.N(N_VEC), .W(WORD_W)) u_scan_req (
        .bits(irr), .found(req_found), .idx(req_idx));
    prio_irq_scan #(.N(N_VEC), .W(WORD_W)) u_scan_svc (
        .bits(isr), .found(svc_found), .idx(svc_idx));
    prio_irq_scan #(.N(N_VEC), .W(WORD_W)) u_scan_mid (
        .bits(isr_mid), .found(mid_found), .idx(mid_idx));

    prio_irq_arb u_arb (
        .req_found (req_found),
        .req_vec   (vec_t'(req_idx)),
        .svc_found (svc_found),
        .svc_vec   (vec_t'(svc_idx)),
        .tpr       (tpr_q),
        .enable    (spur_q[EN_BIT]),
        .arb       (arb)
    );

    assign take    = ack && arb.has_req && !arb.blocked;
    assign retire  = eoi && mid_found;
    assign bc_fire = retire && tmr[mid_idx] && !supp_q;

    prio_irq_vecs #(.N(N_VEC)) u_vecs (
        .clk        (clk),
        .rst        (rst),
        .set_vld    (set_vld),
        .set_vec    (IW'(set_vec)),
        .set_lvl    (set_lvl),
        .take_vld   (take),
        .take_vec   (req_idx),
        .retire_vld (retire),
        .retire_vec (mid_idx),
        .irr        (irr),
        .isr        (isr),
        .tmr        (tmr),
        .isr_mid    (isr_mid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tpr_q <= '0;
            spur_q <= SPUR_W'(9'h0FF);
        end else begin
            if (tpr_we)          tpr_q <= tpr_wdata;
            else if (tpr_nib_we) tpr_q <= {tpr_nib, 4'h0};
            if (spur_we)         spur_q <= spur_wdata[SPUR_W-1:0];
        end
    end

    if (SUPPRESS_EN) begin : g_supp
        always_ff @(posedge clk) begin
            if (rst)          supp_q <= 1'b0;
            else if (spur_we) supp_q <= spur_wdata[SUPP_BIT];
        end
    end else begin : g_nosupp
        assign supp_q = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            ppr_q  <= '0;
            ack_q  <= '0;
            bc_q   <= '0;
        end else begin
            pend_q     <= arb.has_req && !arb.blocked;
            ppr_q      <= arb.ppr;
            ack_q.vld  <= ack && arb.has_req;
            if (ack && arb.has_req)
                ack_q.vec <= arb.blocked ? spur_q[VEC_W-1:0] : vec_t'(req_idx);
            bc_q.vld   <= bc_fire;
            if (bc_fire) bc_q.vec <= vec_t'(mid_idx);
        end
    end

    assign irq_pending = pend_q;
    assign ppr         = ppr_q;
    assign ack_vld     = ack_q.vld;
    assign ack_vec     = ack_q.vec;
    assign eoi_bcast   = bc_q.vld;
    assign eoi_vec     = bc_q.vec;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       ack,
    input logic       eoi,
    input logic       ack_vld,
    input logic       eoi_bcast,
    input logic       irq_pending,
    input logic [7:0] ppr,
    input logic [8:0] spur_q,
    input logic [7:0] tpr_q
);
    // R4: a response needs an acknowledge one cycle earlier
    a_r4_ack_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> $past(ack));

    // R6: a broadcast needs an end-of-interrupt one cycle earlier
    a_r6_bcast_needs_eoi: assert property (@(posedge clk) disable iff (rst)
        eoi_bcast |-> $past(eoi));

    // R3: pending only while enabled in the previous cycle
    a_r3_pend_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> $past(spur_q[8]));

    // R2: processor priority never below the task priority
    a_r2_ppr_floor: assert property (@(posedge clk) disable iff (rst)
        ppr >= $past(tpr_q));

    // R10: outputs quiet right after reset
    a_r10_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!irq_pending && ppr == 8'h00 && !ack_vld && !eoi_bcast));
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ack         (ack),
    .eoi         (eoi),
    .ack_vld     (ack_vld),
    .eoi_bcast   (eoi_bcast),
    .irq_pending (irq_pending),
    .ppr         (ppr),
    .spur_q      (spur_q),
    .tpr_q       (tpr_q)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_vld = 0, set_lvl = 0, ack = 0, eoi = 0;
    logic [7:0]  set_vec = '0;
    logic        tpr_we = 0, tpr_nib_we = 0, spur_we = 0;
    logic [7:0]  tpr_wdata = '0;
    logic [3:0]  tpr_nib = '0;
    logic [15:0] spur_wdata = '0;
    logic        irq_pending, ack_vld, eoi_bcast;
    logic [7:0]  ack_vec, ppr, eoi_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst(rst), .set_vld(set_vld), .set_vec(set_vec), .set_lvl(set_lvl),
        .ack(ack), .eoi(eoi), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .tpr_nib_we(tpr_nib_we), .tpr_nib(tpr_nib), .spur_we(spur_we),
        .spur_wdata(spur_wdata), .irq_pending(irq_pending), .ack_vld(ack_vld),
        .ack_vec(ack_vec), .ppr(ppr), .eoi_bcast(eoi_bcast), .eoi_vec(eoi_vec));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic post(input logic [7:0] v, input logic lvl);
        set_vld = 1; set_vec = v; set_lvl = lvl;
        tick();
        set_vld = 0;
    endtask

    task automatic do_ack(input string tag, input logic vld_e, input logic [7:0] vec_e);
        ack = 1;
        tick();
        ack = 0;
        chk({tag, " ack_vld"}, ack_vld, vld_e);
        if (vld_e) chk({tag, " ack_vec"}, ack_vec, vec_e);
    endtask

    task automatic do_eoi(input string tag, input logic bc_e, input logic [7:0] vec_e);
        eoi = 1;
        tick();
        eoi = 0;
        chk({tag, " eoi_bcast"}, eoi_bcast, bc_e);
        if (bc_e) chk({tag, " eoi_vec"}, eoi_vec, vec_e);
    endtask

    task automatic wr_tpr(input logic [7:0] v);
        tpr_we = 1; tpr_wdata = v; tick(); tpr_we = 0;
    endtask

    task automatic wr_nib(input logic [3:0] v);
        tpr_nib_we = 1; tpr_nib = v; tick(); tpr_nib_we = 0;
    endtask

    task automatic wr_spur(input logic [15:0] v);
        spur_we = 1; spur_wdata = v; tick(); spur_we = 0;
    endtask

    task automatic settle_chk(input string tag, input logic pend_e, input logic [7:0] ppr_e);
        tick();
        chk({tag, " irq_pending"}, irq_pending, pend_e);
        chk({tag, " ppr"}, ppr, ppr_e);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) tick();
        rst = 0;
        chk("R10 reset pending", irq_pending, 0);
        chk("R10 reset ppr", ppr, 0);
        chk("R10 reset ack_vld", ack_vld, 0);
        chk("R10 reset bcast", eoi_bcast, 0);
    endtask

    task automatic t_disabled();
        post(8'h40, 0);
        settle_chk("R3 disabled", 0, 8'h00);
        do_ack("R3 disabled", 0, 8'h00);
    endtask

    task automatic t_enable();
        wr_spur(16'h013F);
        chk("R9 pending one cycle late", irq_pending, 0);
        tick();
        chk("R3 enabled pending", irq_pending, 1);
        do_ack("R4 deliver", 1, 8'h40);
        settle_chk("R2 ppr from service", 0, 8'h40);
    endtask

    task automatic t_order();
        post(8'h21, 0);
        post(8'h91, 0);
        post(8'h35, 0);
        settle_chk("R1 higher class pending", 1, 8'h40);
        do_ack("R1 highest vector", 1, 8'h91);
        settle_chk("R2 ppr raised", 0, 8'h90);
        do_ack("R4 blocked spurious", 1, 8'h3F);
        settle_chk("R4 state kept", 0, 8'h90);
        do_ack("R4 spurious again", 1, 8'h3F);
    endtask

    task automatic t_eoi();
        do_eoi("R6 edge retire", 0, 8'h00);
        settle_chk("R6 top retired", 0, 8'h40);
        do_eoi("R6 second retire", 0, 8'h00);
        settle_chk("R6 service empty", 1, 8'h00);
        do_eoi("R6 empty eoi", 0, 8'h00);
        settle_chk("R6 empty eoi no change", 1, 8'h00);
    endtask

    task automatic t_tpr();
        wr_tpr(8'h50);
        settle_chk("R3 tpr blocks", 0, 8'h50);
        wr_nib(4'h2);
        settle_chk("R8 nibble write", 1, 8'h20);
        wr_nib(4'h3);
        settle_chk("R3 equal class blocked", 0, 8'h30);
        wr_tpr(8'h00);
        do_ack("R4 deliver 35", 1, 8'h35);
        wr_tpr(8'h3A);
        settle_chk("R2 tpr class wins", 0, 8'h3A);
        wr_tpr(8'h27);
        settle_chk("R2 service class wins", 0, 8'h30);
        wr_tpr(8'h00);
        do_eoi("R6 retire 35", 0, 8'h00);
        settle_chk("R6 after 35", 1, 8'h00);
    endtask

    task automatic t_level();
        post(8'hA0, 1);
        do_ack("R5 level ack", 1, 8'hA0);
        do_eoi("R6 level broadcast", 1, 8'hA0);
        wr_spur(16'h113F);
        post(8'hA0, 1);
        do_ack("R7 ack after write", 1, 8'hA0);
        do_eoi("R7 suppression dropped", 1, 8'hA0);
        post(8'hB0, 1);
        post(8'hB0, 0);
        do_ack("R5 retrigger ack", 1, 8'hB0);
        do_eoi("R5 edge overrides level", 0, 8'h00);
    endtask

    task automatic t_same();
        post(8'h70, 1);
        ack = 1; eoi = 1;
        tick();
        ack = 0; eoi = 0;
        chk("R9 same-cycle ack_vec", ack_vec, 8'h70);
        chk("R9 same-cycle bcast", eoi_bcast, 1);
        chk("R9 same-cycle eoi_vec", eoi_vec, 8'h70);
        settle_chk("R9 after same-cycle", 1, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_disabled();
        t_enable();
        t_order();
        t_eoi();
        t_tpr();
        t_level();
        t_same();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule